// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer Unit

This unit contains a parameterized number of identical timers, three by default. Each timer has a mode selected in its configuration register. In waveform mode it drives a pulse train on its pin. In capture mode it measures the high time and the repetition interval of a signal on its pin. In watchdog mode it raises an interrupt when its pin shows no transition for a programmed number of clocks. Each timer has one pin, brought out as separate input, output and output-enable signals. The pin drives only in waveform mode and only while the timer is enabled.

Software reaches the unit through a word-addressed read/write port. Read data is a combinational function of the address. A shared control word holds one enable bit and one sticky event flag per timer. Each timer also has four registers: configuration, count, period and width. A timer raises its interrupt line while its flag is set and its interrupt enable bit is on. Waveform and watchdog modes both re-arm by themselves, so either mode can produce periodic interrupts.

Top module: `gptmr_unit`

## Requirements
- R1: After reset all readable registers read zero, every `pin_oe` bit is 0 and every `irq` bit is 0.
- R2: Address 0 is the control word. Bits [N-1:0] are the timer enables and are read/write. Bits [8+N-1:8] are the event flags. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle as a clear wins, so the flag stays set.
- R3: Timer i occupies addresses 4*(i+1) to 4*(i+1)+3, in the order configuration, count, period, width. Configuration bit 5 always reads 0. The count register cannot be written.
- R4: The configuration mode field is bits [1:0]: 00 idle, 01 waveform, 10 capture, 11 watchdog. In waveform mode, with the timer enabled, `pin_oe` is 1. The count steps 0,1,2,…,P,1,2,…, where P is the period. The flag sets on each clock at which the count equals P.
- R5: In waveform mode the pin is active while 1 <= count <= width, and inactive otherwise. Configuration bit 2 selects the active level: 0 means high and 1 means low.
- R6: In capture mode the pin input passes through a 2-flop synchronizer. Each rising edge loads the period register with the number of clocks since the previous rising edge. Each falling edge loads the width register with the number of clocks the input was high.
- R7: In capture mode, configuration bit 4 selects which edge sets the flag. When bit 4 is 0, only falling (width) edges set it. When bit 4 is 1, only rising (period) edges set it.
- R8: In watchdog mode the count increments every clock, and any synchronized pin edge clears it to 0. When the count equals the period with no edge present, the flag sets and the count restarts at 0.
- R9: `irq[i]` equals flag i AND configuration bit 3 of timer i. The flag is set whether or not bit 3 is on.
- R10: While a timer's enable bit is 0, its count is held at 0, its `pin_oe` is 0 and it produces no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rdata | output | DATA_W | Read data for `addr` |
| pin_in | input | N_TMR | Pin input levels |
| pin_out | output | N_TMR | Pin output levels |
| pin_oe | output | N_TMR | Pin drive enables |
| irq | output | N_TMR | Per-timer interrupt lines |

## Verification
The embedded properties check several rules on every cycle:
- a disabled timer's count returns to zero;
- the waveform counter reloads to one after it matches the period;
- a capture rising edge latches the running count into the period register;
- a watchdog edge clears the count;
- a flag never drops except through a one-written clear.

Some behaviour only the directed scenarios can show: the exact pin waveform and its polarity, the measured capture values for a known input, the choice of edge that sets a capture flag, and the watchdog firing only once edges stop. The address map and the gating of interrupts by the enable bit are also covered only by those scenarios.

// File: rtl/gptmr_pkg.sv
// Shared types for the general-purpose timer unit.
// Assumes the configuration fields are packed LSB-first as the brief lists them.
package gptmr_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_WAVE = 2'b01,
        MODE_CAPT = 2'b10,
        MODE_WDOG = 2'b11
    } tmr_mode_e;

    // Configuration bits 4:0. Bit 5 is not stored and reads zero.
    typedef struct packed {
        logic      cap_on_per;   // bit 4: capture flag on the period edge
        logic      irq_en;       // bit 3: interrupt enable
        logic      pol_low;      // bit 2: active level is low
        tmr_mode_e mode;         // bits 1:0
    } tmr_cfg_t;

    localparam int CFG_STORED_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/gptmr_sync.sv
// Multi-flop synchronizer followed by single-cycle edge detection.
// Assumes din is asynchronous to clk; rise and fall each pulse for one clock.
module gptmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/gptmr_chan.sv
// One timer: configuration, count, period and width registers plus mode logic.
// Assumes write strobes are already decoded. A hardware capture takes priority
// over a software write to the same register.
module gptmr_chan
    import gptmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_cfg,
    input  logic              wr_per,
    input  logic              wr_wid,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output tmr_cfg_t          cfg_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] per_q,
    output logic [DATA_W-1:0] wid_q,
    output logic              evt
);
    logic              rise, fall;
    logic [DATA_W-1:0] cnt_d;
    logic              cap_per, cap_wid;
    logic              wave_on;

    gptmr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .rise(rise), .fall(fall)
    );

    // Hold the configuration written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= tmr_cfg_t'(wdata[CFG_STORED_W-1:0]);
    end

    // Mode logic: next count, capture strobes and the event pulse.
    always_comb begin
        cnt_d   = cnt_q;
        evt     = 1'b0;
        cap_per = 1'b0;
        cap_wid = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else begin
            case (cfg_q.mode)
                MODE_WAVE: begin
                    if (cnt_q == per_q) begin
                        cnt_d = DATA_W'(1);
                        evt   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                MODE_CAPT: begin
                    if (rise) begin
                        cnt_d   = DATA_W'(1);
                        cap_per = 1'b1;
                        evt     = cfg_q.cap_on_per;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                    if (fall) begin
                        cap_wid = 1'b1;
                        evt     = ~cfg_q.cap_on_per;
                    end
                end
                MODE_WDOG: begin
                    if (rise || fall) begin
                        cnt_d = '0;
                    end else if (cnt_q == per_q) begin
                        cnt_d = '0;
                        evt   = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: cnt_d = '0;
            endcase
        end
    end

    // Register the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Period register: capture on a rising edge, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       per_q <= '0;
        else if (cap_per) per_q <= cnt_q;
        else if (wr_per)  per_q <= wdata;
    end

    // Width register: capture on a falling edge, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       wid_q <= '0;
        else if (cap_wid) wid_q <= cnt_q;
        else if (wr_wid)  wid_q <= wdata;
    end

    assign wave_on = en && (cfg_q.mode == MODE_WAVE);
    assign pin_oe  = wave_on;
    assign pin_out = (wave_on && (cnt_q != '0) && (cnt_q <= wid_q)) ^ cfg_q.pol_low;

    // R10
    disable_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);

    // R4
    wave_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && cfg_q.mode == MODE_WAVE && cnt_q == per_q |=> cnt_q == DATA_W'(1));

    // R6
    capt_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && cfg_q.mode == MODE_CAPT && rise |=> per_q == $past(cnt_q));

    // R8
    wdog_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && cfg_q.mode == MODE_WDOG && (rise || fall) |=> cnt_q == '0);
endmodule

// File: rtl/gptmr_unit.sv
// Timer unit top: decodes the register port, holds the shared control word
// (enables and sticky flags) and instantiates one channel per timer.
// Assumes N_TMR <= 8 so the flags fit above bit 8, and that ADDR_W covers
// 4*(N_TMR+1) words.
module gptmr_unit
    import gptmr_pkg::*;
#(
    parameter int N_TMR       = 3,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_TMR-1:0]  pin_in,
    output logic [N_TMR-1:0]  pin_out,
    output logic [N_TMR-1:0]  pin_oe,
    output logic [N_TMR-1:0]  irq
);
    localparam int FLAG_LSB = 8;
    localparam int SEL_W    = ADDR_W - 2;

    logic [N_TMR-1:0]  en_q, flag_q, evt_v, clr_v;
    logic              ctrl_wr;
    tmr_cfg_t          cfg_a [N_TMR];
    logic [DATA_W-1:0] cnt_a [N_TMR];
    logic [DATA_W-1:0] per_a [N_TMR];
    logic [DATA_W-1:0] wid_a [N_TMR];

    assign ctrl_wr = wr_en && (addr == '0);
    assign clr_v   = ctrl_wr ? wdata[FLAG_LSB +: N_TMR] : '0;

    // Control word: enables are loaded on a write, flags are set by events
    // and cleared by written ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (ctrl_wr) en_q <= wdata[N_TMR-1:0];
            flag_q <= (flag_q & ~clr_v) | evt_v;
        end
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic blk_sel;
        assign blk_sel = wr_en && (addr[ADDR_W-1:2] == SEL_W'(i + 1));

        gptmr_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) chan_i (
            .clk(clk), .rst_n(rst_n), .en(en_q[i]),
            .wr_cfg(blk_sel && addr[1:0] == 2'd0),
            .wr_per(blk_sel && addr[1:0] == 2'd2),
            .wr_wid(blk_sel && addr[1:0] == 2'd3),
            .wdata(wdata), .pin_in(pin_in[i]),
            .pin_out(pin_out[i]), .pin_oe(pin_oe[i]),
            .cfg_q(cfg_a[i]), .cnt_q(cnt_a[i]), .per_q(per_a[i]),
            .wid_q(wid_a[i]), .evt(evt_v[i])
        );

        assign irq[i] = flag_q[i] & cfg_a[i].irq_en;

        // R2
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flag_q[i] && !(ctrl_wr && wdata[FLAG_LSB + i]) |=> flag_q[i]);
    end

    // Read mux: control word at 0, then four words per timer.
    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata[N_TMR-1:0]          = en_q;
            rdata[FLAG_LSB +: N_TMR]  = flag_q;
        end
        for (int i = 0; i < N_TMR; i++) begin
            if (addr[ADDR_W-1:2] == SEL_W'(i + 1)) begin
                case (addr[1:0])
                    2'd0:    rdata = DATA_W'(cfg_a[i]);
                    2'd1:    rdata = cnt_a[i];
                    2'd2:    rdata = per_a[i];
                    default: rdata = wid_a[i];
                endcase
            end
        end
    end
endmodule

// File: tb/gptmr_unit_tb_top.sv
// Directed bench for the timer unit. Each task drives one scenario and checks it.
module gptmr_unit_tb_top;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    gptmr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'd0, v);  chk("R1 ctrl", v, 0);
        rd(4'd4, v);  chk("R1 cfg0", v, 0);
        rd(4'd10, v); chk("R1 per1", v, 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(4'd4, 32'h3F);
        rd(4'd4, v); chk("R3 cfg bit5 zero", v, 32'h1F);
        wr(4'd5, 32'h55);
        rd(4'd5, v); chk("R3 count read-only", v, 0);
        wr(4'd11, 32'h77);
        rd(4'd11, v); chk("R3 width addr", v, 32'h77);
    endtask

    task automatic t_wave;
        logic [31:0] v;
        int c;
        wr(4'd6, 32'd5);
        wr(4'd7, 32'd2);
        wr(4'd4, 32'h09);
        wr(4'd0, 32'h1);
        addr = 4'd5;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk); #1;
            c = ((k - 1) % 5) + 1;
            chk("R4 count seq", rdata, 32'(c));
            chk("R5 pin active high", 32'(pin_out[0]), 32'(c <= 2));
            chk("R4 pin_oe", 32'(pin_oe[0]), 1);
        end
        chk("R4 wave irq", 32'(irq[0]), 1);
        rd(4'd0, v); chk("R4 flag0", v[8], 1);
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0D);
        wr(4'd0, 32'h1);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #1;
            c = ((k - 1) % 5) + 1;
            chk("R5 pin active low", 32'(pin_out[0]), 32'(!(c <= 2)));
        end
    endtask

    task automatic t_disable;
        logic [31:0] v;
        wr(4'd0, 32'h100);
        repeat (2) @(negedge clk);
        rd(4'd5, v); chk("R10 count cleared", v, 0);
        chk("R10 pin_oe off", 32'(pin_oe[0]), 0);
        rd(4'd0, v); chk("R2 flag0 w1c", v[8], 0);
        repeat (8) @(negedge clk);
        rd(4'd0, v); chk("R10 no event when off", v[8], 0);
    endtask

    task automatic t_capture;
        logic [31:0] v;
        wr(4'd8, 32'h0A);
        wr(4'd0, 32'h2);
        for (int p = 0; p < 4; p++) begin
            pin_in[1] = 1'b1;
            repeat (3) @(negedge clk);
            pin_in[1] = 1'b0;
            repeat (5) @(negedge clk);
        end
        rd(4'd10, v); chk("R6 period", v, 8);
        rd(4'd11, v); chk("R6 width", v, 3);
        chk("R6 pin_oe input", 32'(pin_oe[1]), 0);
        wr(4'd0, 32'h702);
        pin_in[1] = 1'b1; repeat (6) @(negedge clk);
        rd(4'd0, v); chk("R7 no flag on rise (bit4=0)", v[9], 0);
        pin_in[1] = 1'b0; repeat (6) @(negedge clk);
        rd(4'd0, v); chk("R7 flag on fall (bit4=0)", v[9], 1);
        chk("R9 irq1", 32'(irq[1]), 1);
        wr(4'd8, 32'h1A);
        wr(4'd0, 32'h702);
        pin_in[1] = 1'b1; repeat (6) @(negedge clk);
        rd(4'd0, v); chk("R7 flag on rise (bit4=1)", v[9], 1);
        wr(4'd0, 32'h702);
        pin_in[1] = 1'b0; repeat (6) @(negedge clk);
        rd(4'd0, v); chk("R7 no flag on fall (bit4=1)", v[9], 0);
    endtask

    task automatic t_wdog;
        logic [31:0] v;
        wr(4'd14, 32'd10);
        wr(4'd12, 32'h03);
        wr(4'd0, 32'h704);
        for (int t = 0; t < 8; t++) begin
            pin_in[2] = ~pin_in[2];
            repeat (5) @(negedge clk);
        end
        rd(4'd0, v); chk("R8 no flag while edges", v[10], 0);
        repeat (20) @(negedge clk);
        rd(4'd0, v); chk("R8 flag when edges stop", v[10], 1);
        chk("R9 irq gated off", 32'(irq[2]), 0);
        wr(4'd12, 32'h0B);
        #1 chk("R9 irq with enable", 32'(irq[2]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_wave();
        t_disable();
        t_capture();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule